// File: doc/BRIEF.md
# Thread-Tagged Shared Translation Buffer

This block is a small translation cache used by two hardware threads of one core. It maps a virtual page number to a physical page number. The two threads share every set and every way. Each stored translation also records the thread that installed it, so a thread only ever hits on its own translations. A lookup takes a thread ID and a virtual page number and returns, in the same cycle, a hit flag and the physical page number.

After a miss, the translation is installed through a fill port. A fill first uses a free way of the addressed set. When the set is full, a way chosen by a free-running pseudo-random sequence is replaced, whoever owns it. A per-thread flush drops all translations of one thread at once. Page-table walking, permissions and multiple page sizes belong to other blocks.

Top module: `thread_tlb`

## Requirements
- R1: After a synchronous active-high reset no translation is valid, and every lookup by either thread misses.
- R2: A lookup is combinational: `lk_hit` and `lk_ppn` reflect the stored state in the request cycle. A fill becomes visible on the clock edge that samples `fl_valid`, and a later lookup of the same thread and page returns the filled physical page number.
- R3: The capacity is 16 sets of 4 ways. The set is the virtual page number modulo 16 (its four low bits), and the remaining 16 upper bits form the stored tag. Pages that differ only in their set bits never disturb each other.
- R4: A lookup hits only when the stored thread ID (1 bit, thread 0 or thread 1) and the stored tag both equal the request. The other thread misses on the same page, and each thread can hold its own translation of one page at the same time.
- R5: A fill into a set that has a free way never evicts anything, so four translations of any owners coexist in one set.
- R6: A fill that matches nothing in a full set replaces exactly one way. The way is picked by the two low bits of a free-running 8-bit LFSR, and the replaced entry may belong to the other thread. Across many sets, more than one way position gets replaced.
- R7: A fill whose thread ID and tag equal a valid entry overwrites that entry in place, with no duplicate and no eviction, so the other ways of the set stay valid.
- R8: A flush clears every entry owned by the flushed thread and leaves the other thread's entries hitting with unchanged physical page numbers.
- R9: When a flush and a fill occur in the same cycle, the flush is applied first. The filled entry stays valid even when it belongs to the flushed thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_tid | input | 1 | Thread issuing the lookup |
| lk_vpn | input | 20 | Virtual page number looked up |
| lk_hit | output | 1 | Lookup found a translation of that thread |
| lk_ppn | output | 20 | Physical page number on a hit, zero on a miss |
| fl_valid | input | 1 | Install a translation this cycle |
| fl_tid | input | 1 | Owner of the installed translation |
| fl_vpn | input | 20 | Virtual page number installed |
| fl_ppn | input | 20 | Physical page number installed |
| flush_valid | input | 1 | Drop all entries of one thread this cycle |
| flush_tid | input | 1 | Thread whose entries are dropped |

## Verification
A corrupted valid bit, thread tag or stored tag shows up at the lookup port with no delay. The very next lookup of the affected page either misses when it should hit or hits for the wrong thread. A wrong victim choice only shows once the set is full. It appears as a second lost translation, or as a kept duplicate, on the first lookup after the fill edge. A flush that spills across threads is caught by the first lookup of the surviving thread. The sweeps therefore probe every set for both threads right after each fill, flush and eviction step.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int TLB_WAYS  = 4;
    parameter int TLB_SETS  = 16;
    parameter int VPN_W     = 20;
    parameter int PPN_W     = 20;
    parameter int TID_W     = 1;
    parameter int LFSR_W    = 8;
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8;

    localparam int WAY_W = $clog2(TLB_WAYS);
    localparam int SET_W = $clog2(TLB_SETS);
    localparam int TAG_W = VPN_W - SET_W;

    typedef logic [TID_W-1:0] tid_t;
    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PPN_W-1:0] ppn_t;
    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [SET_W-1:0] set_t;
    typedef logic [WAY_W-1:0] way_t;
    typedef logic [TLB_WAYS-1:0] way_vec_t;

    typedef struct packed {
        logic valid;
        tid_t tid;
        tag_t tag;
        ppn_t ppn;
    } tlb_entry_t;

    typedef tlb_entry_t [TLB_WAYS-1:0] tlb_row_t;

    // Power-of-two set count: modulo is the low bits.
    function automatic set_t set_of(input vpn_t v);
        return v[SET_W-1:0];
    endfunction

    function automatic tag_t tag_of(input vpn_t v);
        return v[VPN_W-1:SET_W];
    endfunction

    function automatic way_t onehot_to_way(input way_vec_t oh);
        way_t r;
        r = '0;
        for (int i = 0; i < TLB_WAYS; i++) begin
            if (oh[i]) r = r | way_t'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [LFSR_W-1:0] state
);
    logic fb;

    assign fb = ^(state & LFSR_TAPS);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LFSR_W'(1);
        end else begin
            state <= {state[LFSR_W-2:0], fb};
        end
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  tlb_row_t row,
    input  tid_t     tid,
    input  tag_t     tag,
    output way_vec_t hit_vec,
    output logic     hit,
    output ppn_t     ppn
);
    ppn_t masked [TLB_WAYS];

    for (genvar w = 0; w < TLB_WAYS; w++) begin : g_way
        assign hit_vec[w] = row[w].valid && (row[w].tid == tid) && (row[w].tag == tag);
        assign masked[w]  = hit_vec[w] ? row[w].ppn : '0;
    end

    always_comb begin
        ppn = '0;
        for (int w = 0; w < TLB_WAYS; w++) begin
            ppn = ppn | masked[w];
        end
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
(
    input  tlb_row_t row,
    input  way_t     rnd_way,
    output way_t     victim
);
    way_vec_t free_vec;
    way_t     first_free;

    for (genvar w = 0; w < TLB_WAYS; w++) begin : g_free
        assign free_vec[w] = !row[w].valid;
    end

    // Lowest-numbered free way wins.
    always_comb begin
        first_free = '0;
        for (int w = TLB_WAYS - 1; w >= 0; w--) begin
            if (free_vec[w]) first_free = way_t'(w);
        end
    end

    assign victim = (|free_vec) ? first_free : rnd_way;
endmodule

// File: rtl/thread_tlb.sv
module thread_tlb
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [TID_W-1:0] lk_tid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fl_valid,
    input  logic [TID_W-1:0] fl_tid,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [PPN_W-1:0] fl_ppn,
    input  logic             flush_valid,
    input  logic [TID_W-1:0] flush_tid
);
    tlb_row_t          mem [TLB_SETS];
    logic [LFSR_W-1:0] rnd;
    way_vec_t          lk_hit_vec;
    way_vec_t          fl_hit_vec;
    logic              fl_match;
    ppn_t              fl_unused_ppn;
    way_t              victim_way;
    way_t              fill_way;
    set_t              fill_set;

    tlb_lfsr u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .state (rnd)
    );

    tlb_match u_lk_match (
        .row     (mem[set_of(lk_vpn)]),
        .tid     (lk_tid),
        .tag     (tag_of(lk_vpn)),
        .hit_vec (lk_hit_vec),
        .hit     (lk_hit),
        .ppn     (lk_ppn)
    );

    tlb_match u_fl_match (
        .row     (mem[set_of(fl_vpn)]),
        .tid     (fl_tid),
        .tag     (tag_of(fl_vpn)),
        .hit_vec (fl_hit_vec),
        .hit     (fl_match),
        .ppn     (fl_unused_ppn)
    );

    tlb_victim u_victim (
        .row     (mem[set_of(fl_vpn)]),
        .rnd_way (rnd[WAY_W-1:0]),
        .victim  (victim_way)
    );

    assign fill_set = set_of(fl_vpn);
    assign fill_way = fl_match ? onehot_to_way(fl_hit_vec) : victim_way;

    // Flush first, fill second: the later assignment wins on a shared entry.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < TLB_SETS; s++) begin
                for (int w = 0; w < TLB_WAYS; w++) begin
                    mem[s][w].valid <= 1'b0;
                end
            end
        end else begin
            if (flush_valid) begin
                for (int s = 0; s < TLB_SETS; s++) begin
                    for (int w = 0; w < TLB_WAYS; w++) begin
                        if (mem[s][w].tid == flush_tid) mem[s][w].valid <= 1'b0;
                    end
                end
            end
            if (fl_valid) begin
                mem[fill_set][fill_way] <= '{valid: 1'b1, tid: fl_tid,
                                             tag: tag_of(fl_vpn), ppn: fl_ppn};
            end
        end
    end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker
    import tlb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [TID_W-1:0] lk_tid,
    input logic [VPN_W-1:0] lk_vpn,
    input logic             lk_hit,
    input logic [PPN_W-1:0] lk_ppn,
    input logic             fl_valid,
    input logic [TID_W-1:0] fl_tid,
    input logic [VPN_W-1:0] fl_vpn,
    input logic [PPN_W-1:0] fl_ppn,
    input logic             flush_valid,
    input logic [TID_W-1:0] flush_tid,
    input way_vec_t         lk_hit_vec
);
    p_reset_empty_r1: assert property (@(posedge clk) rst |=> !lk_hit);

    p_fill_visible_r2: assert property (@(posedge clk) disable iff (rst)
        fl_valid |=> ((lk_tid == $past(fl_tid) && lk_vpn == $past(fl_vpn))
                      -> (lk_hit && lk_ppn == $past(fl_ppn))));

    p_single_hit_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hit_vec));

    p_flush_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && !fl_valid) |=> ((lk_tid == $past(flush_tid)) -> !lk_hit));
endmodule

bind thread_tlb tlb_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .lk_tid      (lk_tid),
    .lk_vpn      (lk_vpn),
    .lk_hit      (lk_hit),
    .lk_ppn      (lk_ppn),
    .fl_valid    (fl_valid),
    .fl_tid      (fl_tid),
    .fl_vpn      (fl_vpn),
    .fl_ppn      (fl_ppn),
    .flush_valid (flush_valid),
    .flush_tid   (flush_tid),
    .lk_hit_vec  (lk_hit_vec)
);

// File: tb/sim_thread_tlb.sv
module sim_thread_tlb;
    logic        clk = 1'b0;
    logic        rst;
    logic        lk_tid;
    logic [19:0] lk_vpn;
    logic        lk_hit;
    logic [19:0] lk_ppn;
    logic        fl_valid;
    logic        fl_tid;
    logic [19:0] fl_vpn;
    logic [19:0] fl_ppn;
    logic        flush_valid;
    logic        flush_tid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    thread_tlb u0 (.*);

    function automatic logic [19:0] mkvpn(input int tag, input int set);
        return 20'((tag << 4) | set);
    endfunction

    function automatic logic [19:0] mkppn(input logic tid, input logic [19:0] vpn, input int gen);
        return 20'(vpn * 3 + (tid ? 20'h11111 : 20'h0) + gen * 20'h40000);
    endfunction

    task automatic look(input logic tid, input logic [19:0] vpn, output logic hit, output logic [19:0] ppn);
        lk_tid = tid;
        lk_vpn = vpn;
        #1;
        hit = lk_hit;
        ppn = lk_ppn;
    endtask

    task automatic expect_hit(input string req, input logic tid, input logic [19:0] vpn, input logic [19:0] exp);
        logic h;
        logic [19:0] p;
        look(tid, vpn, h, p);
        n_tests++;
        if (!h || p !== exp) begin
            n_fail++;
            $display("FAIL %s: tid %0d vpn %h hit %0b ppn %h, expected hit 1 ppn %h", req, tid, vpn, h, p, exp);
        end
    endtask

    task automatic expect_miss(input string req, input logic tid, input logic [19:0] vpn);
        logic h;
        logic [19:0] p;
        look(tid, vpn, h, p);
        n_tests++;
        if (h !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: tid %0d vpn %h hit %0b, expected hit 0", req, tid, vpn, h);
        end
    endtask

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fill(input logic tid, input logic [19:0] vpn, input logic [19:0] ppn);
        @(negedge clk);
        fl_valid = 1'b1; fl_tid = tid; fl_vpn = vpn; fl_ppn = ppn;
        @(negedge clk);
        fl_valid = 1'b0;
    endtask

    task automatic flush(input logic tid);
        @(negedge clk);
        flush_valid = 1'b1; flush_tid = tid;
        @(negedge clk);
        flush_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic h;
        logic [19:0] p;
        bit [3:0] lost_pos;
        rst = 1'b1; fl_valid = 1'b0; fl_tid = 1'b0; fl_vpn = '0; fl_ppn = '0;
        flush_valid = 1'b0; flush_tid = 1'b0; lk_tid = 1'b0; lk_vpn = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: empty after reset, every set, both threads
        for (int s = 0; s < 16; s++) begin
            for (int t = 0; t < 2; t++) begin
                expect_miss("R1 reset", t[0], mkvpn(1, s));
                expect_miss("R1 reset", t[0], mkvpn(0, s));
            end
        end

        // R5/R4: two translations per thread per set, same pages for both threads
        for (int s = 0; s < 16; s++) begin
            for (int g = 1; g <= 2; g++) begin
                fill(1'b0, mkvpn(g, s), mkppn(1'b0, mkvpn(g, s), 0));
                expect_hit("R2 fill visible", 1'b0, mkvpn(g, s), mkppn(1'b0, mkvpn(g, s), 0));
                expect_miss("R4 other thread", 1'b1, mkvpn(g, s));
                fill(1'b1, mkvpn(g, s), mkppn(1'b1, mkvpn(g, s), 0));
            end
        end
        for (int s = 0; s < 16; s++) begin
            for (int g = 1; g <= 2; g++) begin
                for (int t = 0; t < 2; t++) begin
                    expect_hit("R5 no eviction while free", t[0], mkvpn(g, s), mkppn(t[0], mkvpn(g, s), 0));
                end
                expect_miss("R3 unfilled tag", g[0], mkvpn(g + 2, s));
            end
        end

        // R7: overwrite in full set keeps the other ways
        for (int s = 0; s < 16; s++) begin
            fill(1'b0, mkvpn(1, s), mkppn(1'b0, mkvpn(1, s), 1));
        end
        for (int s = 0; s < 16; s++) begin
            expect_hit("R7 overwritten", 1'b0, mkvpn(1, s), mkppn(1'b0, mkvpn(1, s), 1));
            expect_hit("R7 kept", 1'b0, mkvpn(2, s), mkppn(1'b0, mkvpn(2, s), 0));
            expect_hit("R7 kept", 1'b1, mkvpn(1, s), mkppn(1'b1, mkvpn(1, s), 0));
            expect_hit("R7 kept", 1'b1, mkvpn(2, s), mkppn(1'b1, mkvpn(2, s), 0));
        end

        // R8: flush thread 1 only
        flush(1'b1);
        for (int s = 0; s < 16; s++) begin
            expect_miss("R8 flushed", 1'b1, mkvpn(1, s));
            expect_miss("R8 flushed", 1'b1, mkvpn(2, s));
            expect_hit("R8 survivor", 1'b0, mkvpn(1, s), mkppn(1'b0, mkvpn(1, s), 1));
            expect_hit("R8 survivor", 1'b0, mkvpn(2, s), mkppn(1'b0, mkvpn(2, s), 0));
        end
        flush(1'b0);
        for (int s = 0; s < 16; s++) begin
            expect_miss("R8 flushed", 1'b0, mkvpn(1, s));
        end

        // R6: full set of thread 0, one fill by thread 1 evicts exactly one
        lost_pos = '0;
        for (int s = 0; s < 16; s++) begin
            int hits;
            int lost;
            for (int g = 0; g < 4; g++) begin
                fill(1'b0, mkvpn(10 + g, s), mkppn(1'b0, mkvpn(10 + g, s), 2));
            end
            fill(1'b1, mkvpn(20, s), mkppn(1'b1, mkvpn(20, s), 2));
            expect_hit("R6 new entry", 1'b1, mkvpn(20, s), mkppn(1'b1, mkvpn(20, s), 2));
            hits = 0;
            lost = 0;
            for (int g = 0; g < 4; g++) begin
                look(1'b0, mkvpn(10 + g, s), h, p);
                if (h && p == mkppn(1'b0, mkvpn(10 + g, s), 2)) hits++;
                else lost = g;
            end
            check("R6 exactly one evicted", hits == 3, hits, 3);
            lost_pos[lost] = 1'b1;
        end
        check("R6 random victim positions", $countones(lost_pos) >= 2, $countones(lost_pos), 2);

        // R9: flush thread 0 and fill thread 0 in the same cycle
        flush(1'b1);
        @(negedge clk);
        flush_valid = 1'b1; flush_tid = 1'b0;
        fl_valid = 1'b1; fl_tid = 1'b0; fl_vpn = mkvpn(30, 5); fl_ppn = mkppn(1'b0, mkvpn(30, 5), 3);
        @(negedge clk);
        flush_valid = 1'b0; fl_valid = 1'b0;
        expect_hit("R9 fill survives flush", 1'b0, mkvpn(30, 5), mkppn(1'b0, mkvpn(30, 5), 3));
        for (int g = 0; g < 4; g++) begin
            expect_miss("R9 old entries flushed", 1'b0, mkvpn(10 + g, 5));
        end

        // R3: same tag in a different set is independent
        fill(1'b1, mkvpn(40, 7), mkppn(1'b1, mkvpn(40, 7), 4));
        expect_hit("R3 set index", 1'b1, mkvpn(40, 7), mkppn(1'b1, mkvpn(40, 7), 4));
        expect_miss("R3 other set", 1'b1, mkvpn(40, 8));

        // R1: reset clears populated state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        expect_miss("R1 after reset", 1'b1, mkvpn(40, 7));
        expect_miss("R1 after reset", 1'b0, mkvpn(30, 5));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule